// File: doc/BRIEF.md
# SPI flash instruction decoder

This block is the command front end of a serial NOR flash on the slave side. It watches the chip select, serial clock and serial data input lines. It oversamples them with the system clock, assembles bytes, and decodes the leading byte of each chip-select frame against a fixed table. Each entry in the table gives the number of address, dummy and data bytes that the instruction expects. Address bytes build a byte address. Data bytes for write-type instructions go to a storage back end one at a time. When a frame closes cleanly, a single accept pulse hands over the command code and the address.

The block holds the write enable latch. Every instruction that modifies storage or configuration is refused unless an earlier, separate frame set that latch, and each modifying instruction that executes clears it again. The block also tracks deep power-down. While the part is powered down, only the release instruction is honoured.

The back end sees only `cmd_code`, `cmd_addr`, `data_stb`/`data_byte` and `cmd_go`. Data strobes can arrive before the frame is known to be valid, so the back end must commit only on `cmd_go`.

Top module: `spi_flash_cmd_front`

## Requirements
- R1: After reset `wel` and `pdown` are 0, and `cmd_go` and `data_stb` stay low until a frame is decoded.
- R2: A frame holding the whole opcode 06h sets `wel` when chip select rises. A frame holding 04h clears it. Each of these also pulses `cmd_go` with the code WREN (1) or WRDI (2) and address 0.
- R3: Program, erase, status-write and lock-write opcodes received while `wel` is 0 produce no `data_stb` and no `cmd_go`, and leave `wel` at 0.
- R4: Opcodes 02h (PGM, code 5) and A2h (PGM2, code 6) take 3 address bytes, most significant first, then data bytes. Each of the first 256 data bytes pulses `data_stb` with that byte, and later bytes are dropped. `cmd_go` carries the code and address when the frame ends.
- R5: Opcodes 20h (SSE, code 7) and D8h (SE, code 8) take 3 address bytes, and C7h (BE, code 9) takes none. Each pulses `cmd_go` with its code and address at frame end.
- R6: The cycle after `cmd_go` for any modifying command, `wel` reads 0.
- R7: A frame that ends before its address is complete, or with a partial byte, is discarded: no `cmd_go`, and `wel` is unchanged.
- R8: Opcode 4Bh (RDOTP, code 3) takes 3 address bytes and 1 dummy byte, needs no latch, and pulses `cmd_go` as soon as the dummy byte completes. It never strobes data and leaves `wel` unchanged.
- R9: Opcode 42h (PGOTP, code 4) takes 3 address bytes and strobes at most 65 data bytes.
- R10: Opcode 01h (WRSR, code 12, no address) and opcode E5h (WRLR, code 13, 3 address bytes) each need the latch and strobe 1 data byte.
- R11: Opcode B9h (DPD, code 10) sets `pdown`. While `pdown` is 1, every opcode except ABh is ignored. ABh (RDPD, code 11) clears `pdown` and pulses `cmd_go`.
- R12: When the last data byte and the rise of chip select are sampled in the same cycle, that byte is still strobed and the command still executes.
- R13: An opcode outside the table is ignored for the whole frame: no strobe, no `cmd_go`, and `wel` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | Chip select, active low; a frame runs from fall to rise |
| spi_sck | input | 1 | Serial clock, mode 0, data sampled on its rising edge |
| spi_di | input | 1 | Serial data in, most significant bit first |
| cmd_code | output | 4 | Code of the command in progress, valid with `cmd_go` or `data_stb` |
| cmd_addr | output | 24 | Assembled address, valid with `cmd_go` |
| cmd_go | output | 1 | One-cycle pulse: command accepted |
| data_stb | output | 1 | One-cycle pulse: `data_byte` holds the next data byte |
| data_byte | output | 8 | Data byte received for a write-type command |
| wel | output | 1 | Write enable latch |
| pdown | output | 1 | Deep power-down state |

## Verification
The end of a frame and the final data byte can land in the same system-clock cycle. This happens when chip select rises while the serial clock falls after the last bit, because the two edges pass through equal synchronizer depth and the byte-valid register adds one cycle. The bench provokes this by holding the last serial clock high for a single system clock and then dropping it together with raising chip select. It judges the result through the scoreboard, which must see the last byte's strobe and then the accept pulse in that order, and by checking that the latch has fallen afterwards. A second shared cycle is checked by assertion: the accept pulse of a modifying command and the clearing of the latch.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;

   typedef enum logic [3:0] {
      CMD_NONE  = 4'd0,
      CMD_WREN  = 4'd1,
      CMD_WRDI  = 4'd2,
      CMD_RDOTP = 4'd3,
      CMD_PGOTP = 4'd4,
      CMD_PGM   = 4'd5,
      CMD_PGM2  = 4'd6,
      CMD_SSE   = 4'd7,
      CMD_SE    = 4'd8,
      CMD_BE    = 4'd9,
      CMD_DPD   = 4'd10,
      CMD_RDPD  = 4'd11,
      CMD_WRSR  = 4'd12,
      CMD_WRLR  = 4'd13
   } cmd_e;

   typedef struct packed {
      cmd_e        code;
      logic        known;
      logic        wel_req;
      logic        has_addr;
      logic        has_dummy;
      logic        is_read;
      logic [15:0] data_max;
   } op_info_t;

   function automatic logic code_needs_wel(input cmd_e c);
      return c inside {CMD_PGOTP, CMD_PGM, CMD_PGM2, CMD_SSE, CMD_SE,
                       CMD_BE, CMD_WRSR, CMD_WRLR};
   endfunction

   function automatic op_info_t op_lookup(input logic [7:0] op,
                                          input logic [15:0] page_n,
                                          input logic [15:0] otp_n);
      op_info_t r;
      r = '0;
      r.code = CMD_NONE;
      r.known = 1'b1;
      case (op)
         8'h06: r.code = CMD_WREN;
         8'h04: r.code = CMD_WRDI;
         8'h4B: begin
            r.code = CMD_RDOTP; r.has_addr = 1'b1; r.has_dummy = 1'b1;
            r.is_read = 1'b1; r.data_max = otp_n;
         end
         8'h42: begin
            r.code = CMD_PGOTP; r.has_addr = 1'b1; r.data_max = otp_n;
         end
         8'h02: begin
            r.code = CMD_PGM; r.has_addr = 1'b1; r.data_max = page_n;
         end
         8'hA2: begin
            r.code = CMD_PGM2; r.has_addr = 1'b1; r.data_max = page_n;
         end
         8'h20: begin r.code = CMD_SSE; r.has_addr = 1'b1; end
         8'hD8: begin r.code = CMD_SE;  r.has_addr = 1'b1; end
         8'hC7: r.code = CMD_BE;
         8'hB9: r.code = CMD_DPD;
         8'hAB: r.code = CMD_RDPD;
         8'h01: begin r.code = CMD_WRSR; r.data_max = 16'd1; end
         8'hE5: begin
            r.code = CMD_WRLR; r.has_addr = 1'b1; r.data_max = 16'd1;
         end
         default: r.known = 1'b0;
      endcase
      r.wel_req = code_needs_wel(r.code);
      return r;
   endfunction

endpackage

// File: rtl/spi_fe_sync.sv
module spi_fe_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_cs_n,
   input  logic raw_sck,
   input  logic raw_di,
   output logic cs_n_s,
   output logic di_s,
   output logic sck_rise,
   output logic cs_rise,
   output logic cs_fall
);
   localparam int       NSIG  = 3;
   localparam logic [NSIG-1:0] RST_V = 3'b100;

   if (STAGES < 2) begin : g_bad_stages
      $error("spi_fe_sync: STAGES must be at least 2");
   end

   logic [NSIG-1:0] raw;
   logic [NSIG-1:0] sync;
   logic            cs_d, sck_d;

   assign raw = {raw_cs_n, raw_sck, raw_di};

   for (genvar g = 0; g < NSIG; g++) begin : g_sync
      logic [STAGES-1:0] pipe;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pipe <= {STAGES{RST_V[g]}};
         else        pipe <= {pipe[STAGES-2:0], raw[g]};
      end
      assign sync[g] = pipe[STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_d  <= 1'b1;
         sck_d <= 1'b0;
      end else begin
         cs_d  <= sync[2];
         sck_d <= sync[1];
      end
   end

   assign cs_n_s   = sync[2];
   assign di_s     = sync[0];
   assign sck_rise = sync[1] & ~sck_d & ~sync[2];
   assign cs_rise  = sync[2] & ~cs_d;
   assign cs_fall  = ~sync[2] & cs_d;
endmodule

// File: rtl/spi_fe_shift.sv
module spi_fe_shift #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cs_n_s,
   input  logic         sck_rise,
   input  logic         di_s,
   output logic         byte_vld,
   output logic [W-1:0] byte_q,
   output logic         on_bound
);
   localparam int BC_W = $clog2(W);

   if (W < 2) begin : g_bad_w
      $error("spi_fe_shift: W must be at least 2");
   end

   logic [BC_W-1:0] bitcnt;
   logic [W-1:0]    sh;
   logic            last_bit;

   assign last_bit = (bitcnt == BC_W'(W - 1));
   assign on_bound = (bitcnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bitcnt   <= '0;
         sh       <= '0;
         byte_q   <= '0;
         byte_vld <= 1'b0;
      end else if (cs_n_s) begin
         bitcnt   <= '0;
         byte_vld <= 1'b0;
      end else if (sck_rise) begin
         sh       <= {sh[W-2:0], di_s};
         bitcnt   <= last_bit ? '0 : bitcnt + 1'b1;
         byte_vld <= last_bit;
         if (last_bit) byte_q <= {sh[W-2:0], di_s};
      end else begin
         byte_vld <= 1'b0;
      end
   end

   // R7
   bound_at_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      byte_vld |-> on_bound);
endmodule

// File: rtl/spi_fe_mode.sv
module spi_fe_mode
   import spi_fe_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic exec,
   input  cmd_e exec_code,
   output logic wel,
   output logic pdown
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wel   <= 1'b0;
         pdown <= 1'b0;
      end else if (exec) begin
         case (exec_code)
            CMD_WREN: wel   <= 1'b1;
            CMD_WRDI: wel   <= 1'b0;
            CMD_DPD:  pdown <= 1'b1;
            CMD_RDPD: pdown <= 1'b0;
            default:  if (code_needs_wel(exec_code)) wel <= 1'b0;
         endcase
      end
   end
endmodule

// File: rtl/spi_fe_seq.sv
module spi_fe_seq
   import spi_fe_pkg::*;
#(
   parameter int W          = 8,
   parameter int ADDR_BYTES = 3,
   parameter int PAGE_BYTES = 256,
   parameter int OTP_BYTES  = 65
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  byte_vld,
   input  logic [W-1:0]          byte_q,
   input  logic                  on_bound,
   input  logic                  cs_rise,
   input  logic                  cs_fall,
   input  logic                  wel,
   input  logic                  pdown,
   output cmd_e                  cmd_code,
   output logic [W*ADDR_BYTES-1:0] cmd_addr,
   output logic                  cmd_go,
   output logic                  data_stb,
   output logic [W-1:0]          data_byte
);
   localparam int AW    = W * ADDR_BYTES;
   localparam int AC_W  = $clog2(ADDR_BYTES) + 1;
   localparam int DMAX  = (PAGE_BYTES > OTP_BYTES) ? PAGE_BYTES : OTP_BYTES;
   localparam int DC_W  = $clog2(DMAX + 1);

   if (ADDR_BYTES < 2) begin : g_bad_addr
      $error("spi_fe_seq: ADDR_BYTES must be at least 2");
   end
   if (DMAX > 65535 || PAGE_BYTES < 1 || OTP_BYTES < 1) begin : g_bad_data
      $error("spi_fe_seq: data byte limits out of range");
   end

   typedef enum logic [2:0] {
      PH_OPC, PH_ADR, PH_DMY, PH_DAT, PH_DONE, PH_SKIP
   } phase_e;

   phase_e          phase;
   op_info_t        info, lu;
   logic            allow;
   logic            ready;
   logic [AC_W-1:0] acnt;
   logic [DC_W-1:0] dcnt;
   logic            end_q, bound_q;
   logic            unused_ok;

   function automatic phase_e after_addr(input op_info_t t);
      if (t.has_dummy)          return PH_DMY;
      else if (t.data_max != 0) return PH_DAT;
      else                      return PH_DONE;
   endfunction

   always_comb begin
      lu    = op_lookup(byte_q[7:0], 16'(PAGE_BYTES), 16'(OTP_BYTES));
      allow = lu.known && (!pdown || lu.code == CMD_RDPD)
              && (!lu.wel_req || wel);
   end

   assign cmd_code  = info.code;
   assign unused_ok = &{1'b0, info.known, info.wel_req, info.has_addr};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= PH_OPC;
         info      <= '0;
         ready     <= 1'b0;
         acnt      <= '0;
         dcnt      <= '0;
         cmd_addr  <= '0;
         cmd_go    <= 1'b0;
         data_stb  <= 1'b0;
         data_byte <= '0;
         end_q     <= 1'b0;
         bound_q   <= 1'b0;
      end else begin
         cmd_go   <= 1'b0;
         data_stb <= 1'b0;
         end_q    <= cs_rise;
         if (cs_rise) bound_q <= on_bound;
         if (cs_fall) begin
            phase <= PH_OPC;
            ready <= 1'b0;
         end else if (end_q) begin
            if (bound_q && ready && phase != PH_SKIP) cmd_go <= 1'b1;
            phase <= PH_OPC;
            ready <= 1'b0;
         end else if (byte_vld) begin
            case (phase)
               PH_OPC: begin
                  cmd_addr <= '0;
                  acnt     <= '0;
                  dcnt     <= '0;
                  if (allow) begin
                     info <= lu;
                     if (lu.has_addr) phase <= PH_ADR;
                     else begin
                        phase <= after_addr(lu);
                        ready <= !lu.is_read;
                     end
                  end else begin
                     phase <= PH_SKIP;
                  end
               end
               PH_ADR: begin
                  cmd_addr <= {cmd_addr[AW-W-1:0], byte_q};
                  if (acnt == AC_W'(ADDR_BYTES - 1)) begin
                     acnt  <= '0;
                     phase <= after_addr(info);
                     ready <= !info.is_read;
                  end else begin
                     acnt <= acnt + 1'b1;
                  end
               end
               PH_DMY: begin
                  if (info.is_read) cmd_go <= 1'b1;
                  phase <= (!info.is_read && info.data_max != 0) ? PH_DAT
                                                                 : PH_DONE;
               end
               PH_DAT: begin
                  if (16'(dcnt) < info.data_max) begin
                     data_stb  <= 1'b1;
                     data_byte <= byte_q;
                     dcnt      <= dcnt + 1'b1;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // R3
   wel_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_go || data_stb) && code_needs_wel(cmd_code) |-> wel);

   // R11
   pd_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_go || data_stb) && pdown |-> cmd_code == CMD_RDPD);

   // R12
   stb_go_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(data_stb && cmd_go));

   // R4
   dcnt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      data_stb |-> 16'(dcnt) <= info.data_max);
endmodule

// File: rtl/spi_flash_cmd_front.sv
module spi_flash_cmd_front
   import spi_fe_pkg::*;
#(
   parameter int ADDR_BYTES  = 3,
   parameter int PAGE_BYTES  = 256,
   parameter int OTP_BYTES   = 65,
   parameter int SYNC_STAGES = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    spi_cs_n,
   input  logic                    spi_sck,
   input  logic                    spi_di,
   output logic [3:0]              cmd_code,
   output logic [8*ADDR_BYTES-1:0] cmd_addr,
   output logic                    cmd_go,
   output logic                    data_stb,
   output logic [7:0]              data_byte,
   output logic                    wel,
   output logic                    pdown
);
   localparam int W = 8;

   logic         cs_n_s, di_s, sck_rise, cs_rise, cs_fall;
   logic         byte_vld, on_bound;
   logic [W-1:0] byte_q;
   cmd_e         code_e;

   spi_fe_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .raw_cs_n(spi_cs_n), .raw_sck(spi_sck), .raw_di(spi_di),
      .cs_n_s(cs_n_s), .di_s(di_s), .sck_rise(sck_rise),
      .cs_rise(cs_rise), .cs_fall(cs_fall)
   );

   spi_fe_shift #(.W(W)) u_shift (
      .clk(clk), .rst_n(rst_n), .cs_n_s(cs_n_s), .sck_rise(sck_rise),
      .di_s(di_s), .byte_vld(byte_vld), .byte_q(byte_q),
      .on_bound(on_bound)
   );

   spi_fe_seq #(.W(W), .ADDR_BYTES(ADDR_BYTES), .PAGE_BYTES(PAGE_BYTES),
                .OTP_BYTES(OTP_BYTES)) u_seq (
      .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_q(byte_q),
      .on_bound(on_bound), .cs_rise(cs_rise), .cs_fall(cs_fall),
      .wel(wel), .pdown(pdown), .cmd_code(code_e), .cmd_addr(cmd_addr),
      .cmd_go(cmd_go), .data_stb(data_stb), .data_byte(data_byte)
   );

   spi_fe_mode u_mode (
      .clk(clk), .rst_n(rst_n), .exec(cmd_go), .exec_code(code_e),
      .wel(wel), .pdown(pdown)
   );

   assign cmd_code = code_e;

   // R6
   wel_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_go && code_needs_wel(code_e) |=> !wel);

   // R11
   pd_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_go && code_e == CMD_DPD |=> pdown);
endmodule

// File: tb/tb_spi_flash_cmd_front.sv
module tb_spi_flash_cmd_front;
   import spi_fe_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1;
   logic        sck = 1'b0;
   logic        di = 1'b0;
   logic [3:0]  cmd_code;
   logic [23:0] cmd_addr;
   logic        cmd_go, data_stb, wel, pdown;
   logic [7:0]  data_byte;

   int checks = 0;
   int errors = 0;

   typedef struct {
      bit          is_go;
      cmd_e        code;
      logic [23:0] addr;
      logic [7:0]  data;
      string       req;
   } ev_t;
   ev_t expq[$];

   logic [7:0] fbuf [0:299];

   always #10 clk = ~clk;

   spi_flash_cmd_front dut (
      .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck),
      .spi_di(di), .cmd_code(cmd_code), .cmd_addr(cmd_addr),
      .cmd_go(cmd_go), .data_stb(data_stb), .data_byte(data_byte),
      .wel(wel), .pdown(pdown)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic push_go(input cmd_e c, input logic [23:0] a,
                          input string r);
      ev_t e;
      e.is_go = 1'b1; e.code = c; e.addr = a; e.data = '0; e.req = r;
      expq.push_back(e);
   endtask

   task automatic push_stb(input cmd_e c, input logic [7:0] d,
                           input string r);
      ev_t e;
      e.is_go = 1'b0; e.code = c; e.addr = '0; e.data = d; e.req = r;
      expq.push_back(e);
   endtask

   // monitor: pops expected events and compares
   always @(negedge clk) begin
      if (rst_n && (cmd_go || data_stb)) begin
         if (expq.size() == 0) begin
            chk(1'b0, "R3", "unexpected event code", int'(cmd_code), 0);
         end else begin
            ev_t e;
            e = expq.pop_front();
            if (e.is_go) begin
               chk(cmd_go && !data_stb, e.req, "go kind", int'(cmd_go), 1);
               chk(cmd_code == e.code && cmd_addr == e.addr, e.req,
                   "go code/addr", int'({cmd_code, cmd_addr}),
                   int'({e.code, e.addr}));
            end else begin
               chk(data_stb && cmd_code == e.code && data_byte == e.data,
                   e.req, "strobe code/data", int'({cmd_code, data_byte}),
                   int'({e.code, e.data}));
            end
         end
      end
   end

   task automatic frame(input int n, input int extra_bits, input bit tight);
      @(negedge clk);
      cs_n = 1'b0;
      repeat (4) @(negedge clk);
      for (int i = 0; i < n; i++) begin
         for (int b = 7; b >= 0; b--) begin
            di = fbuf[i][b];
            repeat (4) @(negedge clk);
            sck = 1'b1;
            if (tight && extra_bits == 0 && i == n - 1 && b == 0) begin
               @(negedge clk);
               sck = 1'b0;
               cs_n = 1'b1;
            end else begin
               repeat (4) @(negedge clk);
               sck = 1'b0;
            end
         end
      end
      for (int k = 0; k < extra_bits; k++) begin
         di = 1'b1;
         repeat (4) @(negedge clk);
         sck = 1'b1;
         repeat (4) @(negedge clk);
         sck = 1'b0;
      end
      if (!cs_n) begin
         repeat (4) @(negedge clk);
         cs_n = 1'b1;
      end
      repeat (12) @(negedge clk);
   endtask

   task automatic put_addr(input logic [23:0] a);
      fbuf[1] = a[23:16]; fbuf[2] = a[15:8]; fbuf[3] = a[7:0];
   endtask

   task automatic one_op(input logic [7:0] op);
      fbuf[0] = op;
      frame(1, 0, 1'b0);
   endtask

   task automatic do_wren();
      push_go(CMD_WREN, 24'h0, "R2");
      one_op(8'h06);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : stim
      repeat (5) @(negedge clk);
      // R1 reset state
      chk(wel == 1'b0 && pdown == 1'b0, "R1", "wel/pdown at reset",
          int'({wel, pdown}), 0);
      chk(!cmd_go && !data_stb, "R1", "go/stb at reset",
          int'({cmd_go, data_stb}), 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk(!cmd_go && !data_stb && !wel, "R1", "idle after reset",
          int'({cmd_go, data_stb, wel}), 0);

      // R3 program refused without latch
      fbuf[0] = 8'h02; put_addr(24'h010203); fbuf[4] = 8'h11; fbuf[5] = 8'h22;
      frame(6, 0, 1'b0);
      chk(wel == 1'b0, "R3", "wel after refused program", int'(wel), 0);
      fbuf[0] = 8'hC7;
      frame(1, 0, 1'b0);
      chk(wel == 1'b0, "R3", "wel after refused bulk erase", int'(wel), 0);

      // R2 set and clear
      do_wren();
      chk(wel == 1'b1, "R2", "wel after 06h", int'(wel), 1);
      push_go(CMD_WRDI, 24'h0, "R2");
      one_op(8'h04);
      chk(wel == 1'b0, "R2", "wel after 04h", int'(wel), 0);

      // R4 page program, R6 latch cleared
      do_wren();
      fbuf[0] = 8'h02; put_addr(24'h123456);
      for (int i = 0; i < 4; i++) begin
         fbuf[4+i] = 8'hC0 + 8'(i);
         push_stb(CMD_PGM, 8'hC0 + 8'(i), "R4");
      end
      push_go(CMD_PGM, 24'h123456, "R4");
      frame(8, 0, 1'b0);
      chk(wel == 1'b0, "R6", "wel after program", int'(wel), 0);

      // R4 dual program with 258 bytes, only 256 strobed
      do_wren();
      fbuf[0] = 8'hA2; put_addr(24'hFEDCBA);
      for (int i = 0; i < 258; i++) begin
         fbuf[4+i] = 8'(i) ^ 8'h5A;
         if (i < 256) push_stb(CMD_PGM2, 8'(i) ^ 8'h5A, "R4");
      end
      push_go(CMD_PGM2, 24'hFEDCBA, "R4");
      frame(262, 0, 1'b0);
      chk(wel == 1'b0, "R6", "wel after dual program", int'(wel), 0);

      // R5 erases
      do_wren();
      fbuf[0] = 8'h20; put_addr(24'h00A000);
      push_go(CMD_SSE, 24'h00A000, "R5");
      frame(4, 0, 1'b0);
      do_wren();
      fbuf[0] = 8'hD8; put_addr(24'h3F0000);
      push_go(CMD_SE, 24'h3F0000, "R5");
      frame(4, 0, 1'b0);
      chk(wel == 1'b0, "R5", "wel after sector erase", int'(wel), 0);
      do_wren();
      push_go(CMD_BE, 24'h0, "R5");
      one_op(8'hC7);
      chk(wel == 1'b0, "R6", "wel after bulk erase", int'(wel), 0);

      // R7 short and partial frames discarded
      do_wren();
      fbuf[0] = 8'hD8; put_addr(24'h112233);
      frame(3, 0, 1'b0);
      chk(wel == 1'b1, "R7", "wel after short address", int'(wel), 1);
      frame(4, 3, 1'b0);
      chk(wel == 1'b1, "R7", "wel after partial byte", int'(wel), 1);
      push_go(CMD_WRDI, 24'h0, "R2");
      one_op(8'h04);

      // R8 read OTP
      fbuf[0] = 8'h4B; put_addr(24'h000010);
      fbuf[4] = 8'h00; fbuf[5] = 8'hFF; fbuf[6] = 8'hFF;
      push_go(CMD_RDOTP, 24'h000010, "R8");
      frame(7, 0, 1'b0);
      chk(wel == 1'b0, "R8", "wel after read", int'(wel), 0);

      // R9 program OTP capped at 65
      do_wren();
      fbuf[0] = 8'h42; put_addr(24'h000020);
      for (int i = 0; i < 66; i++) begin
         fbuf[4+i] = 8'h80 ^ 8'(i);
         if (i < 65) push_stb(CMD_PGOTP, 8'h80 ^ 8'(i), "R9");
      end
      push_go(CMD_PGOTP, 24'h000020, "R9");
      frame(70, 0, 1'b0);
      chk(wel == 1'b0, "R9", "wel after OTP program", int'(wel), 0);

      // R10 status and lock writes
      do_wren();
      fbuf[0] = 8'h01; fbuf[1] = 8'h9C;
      push_stb(CMD_WRSR, 8'h9C, "R10");
      push_go(CMD_WRSR, 24'h0, "R10");
      frame(2, 0, 1'b0);
      do_wren();
      fbuf[0] = 8'hE5; put_addr(24'h00ABCD); fbuf[4] = 8'h3C;
      push_stb(CMD_WRLR, 8'h3C, "R10");
      push_go(CMD_WRLR, 24'h00ABCD, "R10");
      frame(5, 0, 1'b0);
      chk(wel == 1'b0, "R10", "wel after lock write", int'(wel), 0);

      // R13 unknown opcode
      do_wren();
      fbuf[0] = 8'h9F; fbuf[1] = 8'h00;
      frame(2, 0, 1'b0);
      chk(wel == 1'b1, "R13", "wel after unknown opcode", int'(wel), 1);

      // R11 deep power-down
      push_go(CMD_DPD, 24'h0, "R11");
      one_op(8'hB9);
      chk(pdown == 1'b1, "R11", "pdown after B9h", int'(pdown), 1);
      one_op(8'h04);
      chk(wel == 1'b1, "R11", "wel after ignored 04h", int'(wel), 1);
      fbuf[0] = 8'h4B; put_addr(24'h0); fbuf[4] = 8'h00;
      frame(5, 0, 1'b0);
      push_go(CMD_RDPD, 24'h0, "R11");
      one_op(8'hAB);
      chk(pdown == 1'b0, "R11", "pdown after ABh", int'(pdown), 0);
      push_go(CMD_WRDI, 24'h0, "R11");
      one_op(8'h04);
      chk(wel == 1'b0, "R11", "wel after release and 04h", int'(wel), 0);

      // R12 last byte and frame end together
      do_wren();
      fbuf[0] = 8'h02; put_addr(24'h0000FF); fbuf[4] = 8'hA5;
      push_stb(CMD_PGM, 8'hA5, "R12");
      push_go(CMD_PGM, 24'h0000FF, "R12");
      frame(5, 0, 1'b1);
      chk(wel == 1'b0, "R12", "wel after tight frame", int'(wel), 0);

      repeat (10) @(negedge clk);
      chk(expq.size() == 0, "R4", "events left unseen", expq.size(), 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule